// File: doc/BRIEF.md
# PWM Channel Enable and Interrupt Controller

This block is the control register file that sits beside a bank of PWM channels. It does not generate waveforms. It holds one enable bit per channel and drives those bits out to the channel logic. It also holds one interrupt mask bit per channel. A sticky event flag for each channel is set whenever that channel reports the end of a period. A single interrupt line rises while any pending flag has its mask bit set.

Software changes enables and masks through paired registers. One register of each pair sets bits and the other clears bits, and only bits written as one take effect. Two read-only registers return the current enables and the current mask. The flag register is cleared by reading it. This lets firmware wait for an end of period, read the flags, and then safely write the next duty or period value into a channel's update register.

The register port addresses words directly: `reg_addr` is a word index. Read data appears on `reg_rdata` in the cycle after `reg_rd_en` is sampled. In every other cycle `reg_rdata` is zero. Only bits [NUM_CH-1:0] of any register carry meaning. All other bits read as zero and are ignored on write.

Top module: `pwm_chan_irq_ctrl`

## Requirements
- R1: After reset, all channel enables, all mask bits and all event flags are zero, `irq` is low and `reg_rdata` is zero.
- R2: A write to address 0 (channel-on) sets every enable bit whose `reg_wdata` bit is one. Bits written as zero keep their value. `chan_en` shows the result one cycle later.
- R3: A write to address 1 (channel-off) clears every enable bit whose `reg_wdata` bit is one. Bits written as zero keep their value.
- R4: A read of address 2 returns the enable bits in `reg_rdata[NUM_CH-1:0]`, with zeros above.
- R5: A write to address 3 sets mask bits and a write to address 4 clears mask bits, with one-bits only. A read of address 5 returns the mask in the low bits.
- R6: A one on `period_end[i]` in a cycle sets event flag i. The flag stays set until it is cleared by a read. A read of address 6 returns the flags in the low bits.
- R7: A read of address 6 returns the flags as they stood before the read and clears all of them.
- R8: An end-of-period event that arrives in the same cycle as a read of address 6 is not returned by that read. Its flag is left set for the next read.
- R9: `irq` is high exactly when some event flag i is set and mask bit i is one. A flag whose mask bit is zero keeps its value but does not drive `irq`.
- R10: Writes to addresses 2, 5, 6 and 7 and above change no state. Reads of addresses 0, 1, 3, 4 and 7 and above return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word index of the register accessed |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after a read, zero otherwise |
| period_end | input | NUM_CH | One-cycle end-of-period pulse per channel |
| chan_en | output | NUM_CH | Enable bit per channel |
| irq | output | 1 | Interrupt request, OR of pending and unmasked flags |

## Verification
The bench builds the block with NUM_CH=4, ADDR_W=4 and DATA_W=32. The four-bit address makes nine unmapped word indices available, so random accesses hit them and exercise R10. The 32-bit data word lets random writes carry ones above bit 3, which shows that high bits are ignored. With four channels, random event pulses often land in the same cycle as a flag read. The random mask patterns also mix masked and unmasked pending flags, so R8 and R9 are exercised without extra setup.

// File: rtl/pwm_irq_pkg.sv
package pwm_irq_pkg;
    // word indices of the register file
    localparam int unsigned OFS_CH_ON    = 0;
    localparam int unsigned OFS_CH_OFF   = 1;
    localparam int unsigned OFS_CH_STAT  = 2;
    localparam int unsigned OFS_IRQ_ON   = 3;
    localparam int unsigned OFS_IRQ_OFF  = 4;
    localparam int unsigned OFS_IRQ_MASK = 5;
    localparam int unsigned OFS_EVT      = 6;
endpackage

// File: rtl/pwm_w1sc_bits.sv
module pwm_w1sc_bits #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_bits,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] bits_q
);
    typedef struct packed {
        logic [N-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits | set_bits) & ~clr_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_q = st_q.bits;
endmodule

// File: rtl/pwm_evt_flags.sv
module pwm_evt_flags #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         rd_clr,
    output logic [N-1:0] flags_q
);
    typedef struct packed {
        logic [N-1:0] flags;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // events of the reading cycle survive the clear
        if (rd_clr) st_d.flags = evt;
        else        st_d.flags = st_q.flags | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q = st_q.flags;
endmodule

// File: rtl/pwm_chan_irq_ctrl.sv
module pwm_chan_irq_ctrl
    import pwm_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] period_end,
    output logic [NUM_CH-1:0] chan_en,
    output logic              irq
);
    localparam int unsigned PAD_W = DATA_W - NUM_CH;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_CH-1:0] wbits;
    logic [NUM_CH-1:0] en_set, en_clr, msk_set, msk_clr;
    logic [NUM_CH-1:0] en_q, mask_q, flags_q;
    logic              evt_rd;

    assign wbits = reg_wdata[NUM_CH-1:0];

    always_comb begin
        en_set  = '0;
        en_clr  = '0;
        msk_set = '0;
        msk_clr = '0;
        if (reg_wr_en) begin
            if (reg_addr == ADDR_W'(OFS_CH_ON))   en_set  = wbits;
            if (reg_addr == ADDR_W'(OFS_CH_OFF))  en_clr  = wbits;
            if (reg_addr == ADDR_W'(OFS_IRQ_ON))  msk_set = wbits;
            if (reg_addr == ADDR_W'(OFS_IRQ_OFF)) msk_clr = wbits;
        end
    end

    assign evt_rd = reg_rd_en && (reg_addr == ADDR_W'(OFS_EVT));

    pwm_w1sc_bits #(.N(NUM_CH)) u_en (
        .clk(clk), .rst_n(rst_n), .set_bits(en_set), .clr_bits(en_clr), .bits_q(en_q)
    );

    pwm_w1sc_bits #(.N(NUM_CH)) u_mask (
        .clk(clk), .rst_n(rst_n), .set_bits(msk_set), .clr_bits(msk_clr), .bits_q(mask_q)
    );

    pwm_evt_flags #(.N(NUM_CH)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt(period_end), .rd_clr(evt_rd), .flags_q(flags_q)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (reg_rd_en) begin
            if (reg_addr == ADDR_W'(OFS_CH_STAT))  st_d.rdata = {{PAD_W{1'b0}}, en_q};
            if (reg_addr == ADDR_W'(OFS_IRQ_MASK)) st_d.rdata = {{PAD_W{1'b0}}, mask_q};
            if (reg_addr == ADDR_W'(OFS_EVT))      st_d.rdata = {{PAD_W{1'b0}}, flags_q};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign chan_en   = en_q;
    assign irq       = |(flags_q & mask_q);
endmodule

// File: rtl/pwm_chan_irq_ctrl_chk.sv
module pwm_chan_irq_ctrl_chk
    import pwm_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr,
    input logic              rd,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [NUM_CH-1:0] pend,
    input logic [NUM_CH-1:0] en,
    input logic [NUM_CH-1:0] mask,
    input logic [NUM_CH-1:0] flags,
    input logic              irq
);
    logic wr_on, wr_off, wr_ro, rd_evt, wr_mask_off;
    assign wr_on       = wr && addr == ADDR_W'(OFS_CH_ON);
    assign wr_off      = wr && addr == ADDR_W'(OFS_CH_OFF);
    assign wr_mask_off = wr && addr == ADDR_W'(OFS_IRQ_OFF);
    assign wr_ro       = wr && (addr == ADDR_W'(OFS_CH_STAT) || addr == ADDR_W'(OFS_IRQ_MASK)
                                || addr >= ADDR_W'(OFS_EVT));
    assign rd_evt      = rd && addr == ADDR_W'(OFS_EVT);

    assert_ch_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_on |=> ((en & $past(wdata[NUM_CH-1:0])) == $past(wdata[NUM_CH-1:0])));

    assert_ch_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_off |=> ((en & $past(wdata[NUM_CH-1:0])) == '0));

    assert_stat_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == ADDR_W'(OFS_CH_STAT)) |=> (rdata[NUM_CH-1:0] == $past(en)));

    assert_evt_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(pend & mask)) && !wr_mask_off) |=> irq);

    assert_rd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && pend == '0) |=> (flags == '0));

    assert_keep_coinc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt |=> (flags == $past(pend)));

    assert_ro_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ro |=> ($stable(en) && $stable(mask)));
endmodule

bind pwm_chan_irq_ctrl pwm_chan_irq_ctrl_chk #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr_en), .rd(reg_rd_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .pend(period_end), .en(chan_en),
    .mask(mask_q), .flags(flags_q), .irq(irq)
);

// File: tb/pwm_chan_irq_ctrl_tb.sv
module pwm_chan_irq_ctrl_tb;
    localparam int NCH = 4;
    localparam int AW  = 4;
    localparam int DW  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr = 1'b0, rd = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NCH-1:0] pe = '0;
    logic [NCH-1:0] chan_en;
    logic          irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [NCH-1:0] en_m = '0, mask_m = '0, flg_m = '0;

    always #10 clk = ~clk;

    pwm_chan_irq_ctrl #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_rd_en(rd), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .period_end(pe), .chan_en(chan_en), .irq(irq)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string rd_tag(input logic [AW-1:0] a);
        case (a)
            4'd2:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R7";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        case (a)
            4'd2:    return DW'(en_m);
            4'd5:    return DW'(mask_m);
            4'd6:    return DW'(flg_m);
            default: return '0;
        endcase
    endfunction

    // one bus cycle: drive at negedge, model, check at following negedge
    task automatic step(input logic w, input logic r, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [NCH-1:0] p, input string tag);
        logic [DW-1:0] exp_rd;
        wr = w; rd = r; addr = a; wdata = d; pe = p;
        exp_rd = r ? exp_read(a) : '0;
        if (w) begin
            case (a)
                4'd0: en_m   = en_m | d[NCH-1:0];
                4'd1: en_m   = en_m & ~d[NCH-1:0];
                4'd3: mask_m = mask_m | d[NCH-1:0];
                4'd4: mask_m = mask_m & ~d[NCH-1:0];
                default: ;
            endcase
        end
        if (r && a == 4'd6) flg_m = p;
        else                flg_m = flg_m | p;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0; pe = '0;
        chk({tag, r ? {" rdata ", rd_tag(a)} : " rdata R10"}, rdata, exp_rd);
        chk({tag, " chan_en R2/R3"}, DW'(chan_en), DW'(en_m));
        chk({tag, " irq R9"}, DW'(irq), DW'(|(flg_m & mask_m)));
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk("R1 chan_en", DW'(chan_en), '0);
        chk("R1 irq", DW'(irq), '0);
        chk("R1 rdata", rdata, '0);
        rst_n = 1'b1;
        @(negedge clk);
        step(0, 1, 4'd6, 0, 0, "R1 flags");
        step(0, 1, 4'd5, 0, 0, "R1 mask");
        // R2: zero bits have no effect; upper bits ignored
        step(1, 0, 4'd0, 32'hFFFF_FFF5, 0, "R2 set");
        step(1, 0, 4'd0, 32'h0, 0, "R2 zero write");
        step(0, 1, 4'd2, 0, 0, "R4 readback");
        // R3
        step(1, 0, 4'd1, 32'h1, 0, "R3 clear");
        step(1, 0, 4'd1, 32'h0, 0, "R3 zero write");
        step(0, 1, 4'd2, 0, 0, "R4 readback2");
        // R5 / R9 masked flag pending
        step(1, 0, 4'd3, 32'h3, 0, "R5 mask on");
        step(0, 0, 4'd0, 0, 4'b0100, "R9 masked event");
        step(0, 0, 4'd0, 0, 4'b0001, "R6 unmasked event");
        step(1, 0, 4'd4, 32'h1, 0, "R5 mask off");
        step(0, 1, 4'd5, 0, 0, "R5 mask read");
        // R10: writes to read-only and unmapped addresses
        step(1, 0, 4'd2, 32'hF, 0, "R10 ro stat");
        step(1, 0, 4'd5, 32'hF, 0, "R10 ro mask");
        step(1, 0, 4'd6, 32'hF, 0, "R10 ro evt");
        step(1, 0, 4'd9, 32'hF, 0, "R10 unmapped");
        step(0, 1, 4'd0, 0, 0, "R10 read wo");
        // R7 / R8: read clears, coincident event kept
        step(0, 1, 4'd6, 0, 4'b1000, "R8 coincident");
        step(0, 1, 4'd6, 0, 0, "R8 next read");
        step(0, 1, 4'd6, 0, 0, "R7 empty");
        // random phase
        for (int i = 0; i < 1500; i++) begin
            logic [2:0] op;
            logic [NCH-1:0] p;
            op = 3'($urandom_range(0, 4));
            p  = (($urandom & 32'h3) == 0) ? NCH'($urandom) : '0;
            step(op == 3'd0 || op == 3'd1, op == 3'd2 || op == 3'd3,
                 (op == 3'd3) ? 4'd6 : AW'($urandom), $urandom, p, "rand R6");
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule